// File: doc/BRIEF.md
# Watchdog Pulse Timer

This block is one channel of an up-counting timer fixed to a watchdog role. Software selects the watchdog-pulse mode, then writes a load value and a compare value and sets the enable bit. The first timer-clock strobe after enable copies the load value into the counter, and every later strobe adds one. Software keeps the system alive by rewriting the load register before the counter runs past its all-ones value. If it fails to, the counter wraps to zero and the block drives one pulse on its pin output. The pulse lasts one timer-clock period and its polarity is selectable. A compare flag and an overflow flag record the two counter events, and each one raises an interrupt request when its own enable bit is set.

The pin is meant to be wired to the system reset line. When the block's own hardware reset is sampled, the pin's level and output-enable are frozen for three more system clocks, so a reset pulse that has already started reaches a valid length. The timer clock arrives as a one-cycle enable strobe, `tick`, taken from the system clock divided by two or from a prescaler outside the block.

Counter state machine: CNT_IDLE (channel inactive) goes to CNT_ARM when the channel becomes active with no strobe and no load write. CNT_IDLE or CNT_ARM goes to CNT_RUN on the first strobe or on a load write. Any state returns to CNT_IDLE when the channel goes inactive. Reset-hold state machine: HOLD_IDLE goes to HOLD_1 on the edge that first samples reset low, then steps HOLD_1 to HOLD_2, HOLD_2 to HOLD_3, and HOLD_3 back to HOLD_IDLE.

Top module: `wdog_pulse_timer`

## Requirements
- R1: The channel is active only while control bit 0 (enable) is 1 and control bits 4:1 (mode) equal 1001b. While the channel is inactive, pin_oe and pin_out are 0 and strobes leave the count unchanged.
- R2: The first tick after the channel becomes active loads the counter with the load register (address 2).
- R3: While running, each tick adds one to the count (read at address 4). Cycles without a tick leave the count unchanged.
- R4: A tick that finds the count equal to the compare register (address 3) sets the compare flag (status bit 0). With control bit 5 (reload) at 0, the count still increments past the compare value.
- R5: With reload at 1, the tick on a compare match loads the counter with the load register value.
- R6: A tick that moves the count from all ones to zero sets the overflow flag (status bit 1). When reload is 1 and the compare value is all ones, the reload wins: the count takes the load value and no overflow occurs.
- R7: While active, pin_oe is 1. On a wrap the pin goes to the pulse level until the next tick, and at all other times it sits at the opposite level. The pulse level is 1 when control bit 6 (invert) is 1 and 0 when it is 0.
- R8: A write to the load register while the channel is active puts the written value into the counter at that same edge, and this takes priority over a tick in that cycle.
- R9: Clearing the enable bit stops counting, keeps the count value, and sets pin_oe to 0.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A flag that is set in the same cycle as a clear stays set.
- R11: irq_cmp equals the compare flag ANDed with control bit 7. irq_ovf equals the overflow flag ANDed with control bit 8.
- R12: On the edge that first samples rst_n low, pin_out and pin_oe keep their pre-reset values for three system clock cycles. After that they return to 0.
- R13: Reset clears the control, status, load, compare and count registers, so all of them read 0. Addresses 5 to 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low, sampled synchronously |
| tick | input | 1 | Timer-clock enable strobe, one system cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 status, 2 load, 3 compare |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read address: 0 to 3 as for writes, 4 count |
| rd_data | output | CNT_W | Read data, combinational from rd_addr |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| pin_out | output | 1 | Pin output level |
| pin_oe | output | 1 | Pin output enable (0 means floating) |

## Verification
The compare match and the overflow can land on the same tick when the compare value is all ones. The bench sets up this case with the load value just below all ones, once with reload at 0 and once with reload at 1. With reload at 0 it expects both flags and a pin pulse. With reload at 1 it expects only the compare flag, the count back at the load value and no pulse. The bench also lines up a status clear with a compare match in one cycle, and a load write with a tick in one cycle, to confirm that the event wins in the first case and the write wins in the second.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_LOAD = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

    localparam logic [3:0] PULSE_MODE = 4'b1001;

    // packed with en at bit 0, mode 4:1, reload 5, inv 6, cmp_ie 7, ovf_ie 8
    typedef struct packed {
        logic       ovf_ie;
        logic       cmp_ie;
        logic       inv;
        logic       reload;
        logic [3:0] mode;
        logic       en;
    } ctrl_t;

    typedef enum logic [1:0] {
        CNT_IDLE,
        CNT_ARM,
        CNT_RUN
    } cnt_state_t;

    typedef enum logic [1:0] {
        HOLD_IDLE,
        HOLD_1,
        HOLD_2,
        HOLD_3
    } hold_state_t;

endpackage

// File: rtl/wdp_regs.sv
module wdp_regs
    import wdp_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic                cmp_evt,
    input  logic                ovf_evt,
    output ctrl_t               ctrl,
    output logic [CNT_W-1:0]    load_val,
    output logic [CNT_W-1:0]    cmp_val,
    output logic                load_wr,
    output logic [CNT_W-1:0]    rd_data,
    output logic                irq_cmp,
    output logic                irq_ovf
);

    localparam int CTRL_W = $bits(ctrl_t);

    logic cmp_flag;
    logic ovf_flag;
    logic stat_wr;

    assign stat_wr = wr_en && (wr_addr == A_STAT);
    assign load_wr = wr_en && (wr_addr == A_LOAD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            load_val <= '0;
            cmp_val  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:  ctrl     <= ctrl_t'(wr_data[CTRL_W-1:0]);
                A_LOAD:  load_val <= wr_data;
                A_CMP:   cmp_val  <= wr_data;
                default: ;
            endcase
        end
    end

    // an event in the same cycle outranks a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            cmp_flag <= cmp_evt | (cmp_flag & ~(stat_wr & wr_data[0]));
            ovf_flag <= ovf_evt | (ovf_flag & ~(stat_wr & wr_data[1]));
        end
    end

    assign irq_cmp = cmp_flag & ctrl.cmp_ie;
    assign irq_ovf = ovf_flag & ctrl.ovf_ie;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data[CTRL_W-1:0] = ctrl;
            A_STAT:  rd_data[1:0]        = {ovf_flag, cmp_flag};
            A_LOAD:  rd_data             = load_val;
            A_CMP:   rd_data             = cmp_val;
            A_CNT:   rd_data             = cnt_i;
            default: rd_data             = '0;
        endcase
    end

    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wr_data[0] && !cmp_evt) |=> !cmp_flag);

    assert_cmp_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> cmp_flag);

    assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);

endmodule

// File: rtl/wdp_counter.sv
module wdp_counter
    import wdp_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_new,
    output logic [CNT_W-1:0] cnt,
    output logic             cmp_evt,
    output logic             ovf_evt,
    output logic             pulse
);

    cnt_state_t       st, st_n;
    logic [CNT_W-1:0] cnt_n;
    logic             pulse_n;
    logic             match;
    logic             at_max;

    assign match  = (cnt == cmp_val);
    assign at_max = &cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= CNT_IDLE;
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            st    <= st_n;
            cnt   <= cnt_n;
            pulse <= pulse_n;
        end
    end

    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        pulse_n = pulse;
        cmp_evt = 1'b0;
        ovf_evt = 1'b0;
        unique case (st)
            CNT_IDLE, CNT_ARM: begin
                pulse_n = 1'b0;
                if (!active) begin
                    st_n = CNT_IDLE;
                end else if (load_wr) begin
                    cnt_n = load_new;
                    st_n  = CNT_RUN;
                end else if (tick) begin
                    cnt_n = load_val;
                    st_n  = CNT_RUN;
                end else begin
                    st_n = CNT_ARM;
                end
            end
            CNT_RUN: begin
                if (!active) begin
                    st_n    = CNT_IDLE;
                    pulse_n = 1'b0;
                end else if (load_wr) begin
                    cnt_n = load_new;
                end else if (tick) begin
                    pulse_n = 1'b0;
                    cmp_evt = match;
                    if (match && reload) begin
                        cnt_n = load_val;
                    end else begin
                        cnt_n = cnt + 1'b1;
                        if (at_max) begin
                            ovf_evt = 1'b1;
                            pulse_n = 1'b1;
                        end
                    end
                end
            end
            default: st_n = CNT_IDLE;
        endcase
    end

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CNT_RUN && active && tick && !load_wr && at_max && !(reload && match))
        |=> (cnt == '0 && pulse));

    assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && tick && !load_wr) |=> !pulse);

    assert_load_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && load_wr) |=> (cnt == $past(load_new)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && st == CNT_IDLE) |=> $stable(cnt));

endmodule

// File: rtl/wdp_pin.sv
module wdp_pin
    import wdp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic inv,
    input  logic pulse,
    output logic pin_out,
    output logic pin_oe
);

    logic        live_out;
    logic        live_oe;
    logic        rst_q    = 1'b0;
    logic        snap_out = 1'b0;
    logic        snap_oe  = 1'b0;
    hold_state_t hold_st  = HOLD_IDLE;
    hold_state_t hold_n;
    logic        rst_seen;

    assign live_oe  = active;
    assign live_out = active & (pulse ? inv : ~inv);
    assign rst_seen = rst_q & ~rst_n;

    // not reset by rst_n: this logic must outlive the reset it reacts to
    always_ff @(posedge clk) begin
        rst_q   <= rst_n;
        hold_st <= hold_n;
        if (hold_st == HOLD_IDLE) begin
            snap_out <= live_out;
            snap_oe  <= live_oe;
        end
    end

    always_comb begin
        hold_n = hold_st;
        unique case (hold_st)
            HOLD_IDLE: if (rst_seen) hold_n = HOLD_1;
            HOLD_1:    hold_n = HOLD_2;
            HOLD_2:    hold_n = HOLD_3;
            HOLD_3:    hold_n = HOLD_IDLE;
            default:   hold_n = HOLD_IDLE;
        endcase
    end

    always_comb begin
        if (hold_st == HOLD_IDLE) begin
            pin_out = live_out;
            pin_oe  = live_oe;
        end else begin
            pin_out = snap_out;
            pin_oe  = snap_oe;
        end
    end

    assert_hold_stable_R12: assert property (@(posedge clk) disable iff (rst_n)
        (hold_st == HOLD_1 || hold_st == HOLD_2) |=> ($stable(pin_out) && $stable(pin_oe)));

    assert_float_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_out);

endmodule

// File: rtl/wdog_pulse_timer.sv
module wdog_pulse_timer
    import wdp_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq_cmp,
    output logic             irq_ovf,
    output logic             pin_out,
    output logic             pin_oe
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cmp_val;
    logic [CNT_W-1:0] cnt;
    logic             load_wr;
    logic             cmp_evt;
    logic             ovf_evt;
    logic             pulse;
    logic             active;

    assign active = ctrl.en && (ctrl.mode == PULSE_MODE);

    wdp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .cnt_i    (cnt),
        .cmp_evt  (cmp_evt),
        .ovf_evt  (ovf_evt),
        .ctrl     (ctrl),
        .load_val (load_val),
        .cmp_val  (cmp_val),
        .load_wr  (load_wr),
        .rd_data  (rd_data),
        .irq_cmp  (irq_cmp),
        .irq_ovf  (irq_ovf)
    );

    wdp_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .active   (active),
        .reload   (ctrl.reload),
        .load_val (load_val),
        .cmp_val  (cmp_val),
        .load_wr  (load_wr),
        .load_new (wr_data),
        .cnt      (cnt),
        .cmp_evt  (cmp_evt),
        .ovf_evt  (ovf_evt),
        .pulse    (pulse)
    );

    wdp_pin u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .inv     (ctrl.inv),
        .pulse   (pulse),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.cmp_ie |-> !irq_cmp) and (!ctrl.ovf_ie |-> !irq_ovf));

endmodule

// File: tb/wdog_pulse_timer_tb.sv
module wdog_pulse_timer_tb;

    localparam int W = 24;
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         irq_cmp, irq_ovf, pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_pulse_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_cmp(irq_cmp), .irq_ovf(irq_ovf),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mk_ctrl(bit en, logic [3:0] mode, bit rl, bit inv, bit cie, bit oie);
        logic [W-1:0] v = '0;
        v[8:0] = {oie, cie, inv, rl, mode, en};
        return v;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_tick(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic chk_cnt(input string req, input logic [W-1:0] exp);
        logic [W-1:0] d;
        rd(3'd4, d);
        check(req, d, exp);
    endtask

    task automatic chk_stat(input string req, input logic [W-1:0] exp);
        logic [W-1:0] d;
        rd(3'd1, d);
        check(req, d, exp);
    endtask

    task automatic setup(input logic [W-1:0] ld, input logic [W-1:0] cm, input logic [W-1:0] ctl);
        wr(3'd0, '0);
        wr(3'd1, 24'd3);
        wr(3'd2, ld);
        wr(3'd3, cm);
        wr(3'd0, ctl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state of every address
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], d);
            check("R13 reset read", d, '0);
        end
        check("R1 reset oe", {23'd0, pin_oe}, '0);

        // R1 wrong mode: no counting, pin floating
        wr(3'd2, 24'd5);
        wr(3'd0, mk_ctrl(1, 4'b1000, 0, 0, 0, 0));
        repeat (3) do_tick();
        chk_cnt("R1 wrong mode count", '0);
        check("R1 wrong mode oe", {23'd0, pin_oe}, '0);
        check("R1 wrong mode out", {23'd0, pin_out}, '0);

        // R2 R3 R7 sweep over start values and polarity
        for (int inv = 0; inv < 2; inv++) begin
            for (int b = 0; b < 3; b++) begin
                logic [W-1:0] base;
                base = (b == 0) ? 24'd0 : (b == 1) ? 24'd100 : 24'h7FFF;
                setup(base, MAXV, mk_ctrl(1, 4'b1001, 0, inv[0], 0, 0));
                do_tick();
                chk_cnt("R2 first tick load", base);
                check("R7 idle level", {23'd0, pin_out}, {23'd0, ~inv[0]});
                check("R7 oe active", {23'd0, pin_oe}, 24'd1);
                for (int k = 1; k <= 12; k++) begin
                    do_tick();
                    chk_cnt("R3 increment", base + k[W-1:0]);
                end
                @(negedge clk);
                chk_cnt("R3 no tick hold", base + 24'd12);
            end
        end

        // R9 disable holds count, floats pin
        rd(3'd4, d);
        wr(3'd0, '0);
        do_tick();
        do_tick();
        chk_cnt("R9 disabled hold", d);
        check("R9 oe", {23'd0, pin_oe}, '0);

        // R4 compare without reload, R11 gating, R10 clear
        setup(24'd10, 24'd13, mk_ctrl(1, 4'b1001, 0, 0, 0, 0));
        for (int k = 0; k < 4; k++) do_tick();
        chk_cnt("R4 at compare", 24'd13);
        chk_stat("R4 before match", '0);
        do_tick();
        chk_cnt("R4 past compare", 24'd14);
        chk_stat("R4 flag", 24'd1);
        check("R11 irq masked", {23'd0, irq_cmp}, '0);
        wr(3'd0, mk_ctrl(1, 4'b1001, 0, 0, 1, 0));
        check("R11 irq enabled", {23'd0, irq_cmp}, 24'd1);
        wr(3'd1, 24'd2);
        chk_stat("R10 write zero keeps", 24'd1);
        wr(3'd1, 24'd1);
        chk_stat("R10 clear", '0);
        check("R11 irq after clear", {23'd0, irq_cmp}, '0);

        // R5 reload cycles
        setup(24'd20, 24'd22, mk_ctrl(1, 4'b1001, 1, 0, 0, 0));
        for (int k = 0; k < 9; k++) begin
            do_tick();
            chk_cnt("R5 reload cycle", 24'd20 + (k % 3));
        end
        chk_stat("R5 flag", 24'd1);

        // R8 load write, alone and against a tick
        wr(3'd2, 24'd500);
        chk_cnt("R8 load write", 24'd500);
        wr_tick(3'd2, 24'd600);
        chk_cnt("R8 write beats tick", 24'd600);
        do_tick();
        chk_cnt("R8 resume", 24'd601);

        // R10 set wins over clear
        setup(24'd30, 24'd31, mk_ctrl(1, 4'b1001, 1, 0, 0, 0));
        do_tick();
        do_tick();
        wr_tick(3'd1, 24'd1);
        chk_cnt("R5 reload at match", 24'd30);
        chk_stat("R10 set beats clear", 24'd1);

        // R6 R7 overflow pulse, both polarities
        for (int inv = 0; inv < 2; inv++) begin
            setup(MAXV - 24'd2, 24'd5, mk_ctrl(1, 4'b1001, 0, inv[0], 0, 1));
            do_tick();
            do_tick();
            do_tick();
            chk_cnt("R6 at max", MAXV);
            chk_stat("R6 no flag yet", '0);
            check("R7 before wrap", {23'd0, pin_out}, {23'd0, ~inv[0]});
            do_tick();
            chk_cnt("R6 wrap", '0);
            chk_stat("R6 overflow flag", 24'd2);
            check("R11 irq ovf", {23'd0, irq_ovf}, 24'd1);
            check("R7 pulse level", {23'd0, pin_out}, {23'd0, inv[0]});
            repeat (3) @(negedge clk);
            check("R7 pulse held to next tick", {23'd0, pin_out}, {23'd0, inv[0]});
            do_tick();
            check("R7 pulse ends", {23'd0, pin_out}, {23'd0, ~inv[0]});
            chk_cnt("R3 after wrap", 24'd1);
        end

        // R6 compare at all ones with reload: reload wins
        setup(MAXV - 24'd1, MAXV, mk_ctrl(1, 4'b1001, 1, 1, 0, 0));
        do_tick();
        do_tick();
        do_tick();
        chk_cnt("R6 reload beats wrap", MAXV - 24'd1);
        chk_stat("R6 compare only", 24'd1);
        check("R7 no pulse", {23'd0, pin_out}, '0);

        // R6 compare at all ones without reload: both flags
        setup(MAXV - 24'd1, MAXV, mk_ctrl(1, 4'b1001, 0, 1, 0, 0));
        do_tick();
        do_tick();
        do_tick();
        chk_cnt("R6 wrap with match", '0);
        chk_stat("R6 both flags", 24'd3);
        check("R7 pulse with match", {23'd0, pin_out}, 24'd1);

        // R12 reset during a high pulse: held three cycles
        @(negedge clk);
        rst_n = 1'b0;
        for (int c = 1; c <= 3; c++) begin
            @(negedge clk);
            check("R12 held out", {23'd0, pin_out}, 24'd1);
            check("R12 held oe", {23'd0, pin_oe}, 24'd1);
        end
        @(negedge clk);
        check("R12 released out", {23'd0, pin_out}, '0);
        check("R12 released oe", {23'd0, pin_oe}, '0);
        repeat (2) @(negedge clk);
        check("R12 stays released", {23'd0, pin_oe}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd0, d);
        check("R13 ctrl after reset", d, '0);
        chk_cnt("R13 count after reset", '0);
        chk_stat("R13 status after reset", '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule